// File: doc/BRIEF.md
# I2C Register-Access Target

This block sits on an I2C bus as a target device. It gives a host byte-wide read and write access to a small register file through an internal address pointer. The block runs on a fast system clock. It brings both bus lines in through a two-flop synchroniser and detects START, STOP and SCL edges on the synchronised samples.

A transfer opens with a START condition. The host then sends an identification byte. Its upper nibble is a fixed prefix and the next three bits must equal the device-select pins.

In a write, the target acknowledges the identification byte, an address byte and each data byte that follows. Every data byte leaves the block as a one-cycle write strobe. The strobe carries the current pointer and the data.

In a read, the host first sets the pointer with a write header. It then issues a repeated START and an identification byte with the read bit set. The target streams register bytes for as long as the host acknowledges them.

The pointer moves up by one after each byte in either direction. It wraps from the last register back to zero. The register file itself lives outside the block and answers combinationally on the read-data input.

Top module: `i2c_reg_target`

## Requirements
- R1: A byte received right after START is accepted only when bits [7:4] are 4'b1010 and bits [3:1] equal dev_sel_i[2:0]. Bit 0 selects the direction (1 = read, 0 = write). An accepted byte is acknowledged by driving SDA low through the ninth SCL clock.
- R2: A non-matching identification byte gets no acknowledge, and SDA stays released. The block then ignores all bus traffic, acknowledges nothing and raises no strobe until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before any START, and after a STOP, bytes on the bus are neither acknowledged nor turned into strobes.
- R4: The address byte after a write identification is acknowledged and loads the pointer. A value above NUM_REGS-1 (8 by default) loads 0.
- R5: Every data byte of a write is received MSB first and acknowledged. It appears as a single-cycle reg_we_o pulse, with reg_addr_o holding the pointer and reg_wdata_o holding the byte.
- R6: The pointer advances by one after each written byte and after each read byte that the host acknowledges. It wraps from NUM_REGS-1 to 0 and never leaves the range 0..NUM_REGS-1.
- R7: After a read identification, the block sends reg_rdata_i for the current pointer, MSB first. The first bit is driven after the acknowledge clock falls and each later bit after an SCL fall. The block releases SDA for the host's acknowledge clock. It keeps sending while the host acknowledges and returns to standby on a non-acknowledge, leaving the pointer where it was.
- R8: sda_oe_o changes only while the synchronised SCL is low, and it is never asserted in standby.
- R9: After reset, SDA is released, no strobe is active and the block is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_sel_i | input | 3 | Device-select pins compared with identification bits [3:1] |
| reg_addr_o | output | PTR_W | Current pointer / register address |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle pulse when a byte is fetched for sending |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The bound checker covers, on every cycle, the rules that need no protocol context. Write strobes last one cycle and occur only in the write-data phase. The pointer stays in range, steps by one and wraps from the last register to zero. SDA is never driven in standby and its driver toggles only while SCL is low.

Some behaviours are only visible across a whole bus transaction, so only the bench's scenarios show them:
- the identification match against the pins;
- the acknowledge bits the host sees;
- the bytes streamed out in a read;
- a pointer that persists from one transfer to the next;
- traffic ignored before START, after STOP and after a non-acknowledge.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WR,
    ST_RD
  } bus_st_e;

  localparam logic [3:0] ID_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    // bus idles high, so reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       load_val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [7:0]       LAST_B = 8'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= (load_val_i > LAST_B) ? '0 : load_val_i[PTR_W-1:0];
    end else if (inc_i) begin
      ptr_q <= (ptr_q == LAST_P) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [2:0]       dev_sel_i,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  output logic             reg_re_o,
  input  logic [7:0]       reg_rdata_i
);
  localparam logic [3:0] CNT_ACK  = 4'd8;  // eight bits seen
  localparam logic [3:0] CNT_SLOT = 4'd9;  // inside acknowledge clock

  logic [1:0] line_s;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  bus_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] shift_q, tx_q, wdata_q;
  logic       rw_q, oe_q, we_q, re_q, ld_q, rinc_q;
  logic       id_hit;

  assign id_hit = (shift_q[7:4] == ID_PREFIX) && (shift_q[3:1] == dev_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      ld_q    <= 1'b0;
      rinc_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      ld_q   <= 1'b0;
      rinc_q <= 1'b0;
      if (start_det) begin
        st_q  <= ST_ID;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          if (st_q == ST_RD) begin
            if (cnt_q == CNT_ACK) begin
              if (!sda_s) begin
                rinc_q <= 1'b1;
                cnt_q  <= CNT_SLOT;
              end else begin
                st_q <= ST_IDLE;  // host declined further data
              end
            end else if (cnt_q < CNT_ACK) begin
              cnt_q <= cnt_q + 4'd1;
            end
          end else if (cnt_q < CNT_ACK) begin
            shift_q <= {shift_q[6:0], sda_s};
            cnt_q   <= cnt_q + 4'd1;
          end
        end else if (scl_fall) begin
          if (st_q == ST_RD) begin
            if (cnt_q == CNT_ACK) begin
              oe_q <= 1'b0;
            end else if (cnt_q == CNT_SLOT) begin
              tx_q  <= reg_rdata_i;
              oe_q  <= ~reg_rdata_i[7];
              re_q  <= 1'b1;
              cnt_q <= '0;
            end else if (cnt_q != '0) begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end else if (cnt_q == CNT_ACK) begin
            case (st_q)
              ST_ID: begin
                if (id_hit) begin
                  oe_q  <= 1'b1;
                  cnt_q <= CNT_SLOT;
                  rw_q  <= shift_q[0];
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                oe_q  <= 1'b1;
                cnt_q <= CNT_SLOT;
                ld_q  <= 1'b1;
              end
              ST_WR: begin
                oe_q    <= 1'b1;
                cnt_q   <= CNT_SLOT;
                we_q    <= 1'b1;
                wdata_q <= shift_q;
              end
              default: ;
            endcase
          end else if (cnt_q == CNT_SLOT) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            if (st_q == ST_ID) begin
              if (rw_q) begin
                st_q <= ST_RD;
                tx_q <= reg_rdata_i;
                oe_q <= ~reg_rdata_i[7];
                re_q <= 1'b1;
              end else begin
                st_q <= ST_ADDR;
              end
            end else if (st_q == ST_ADDR) begin
              st_q <= ST_WR;
            end
          end
        end
      end
    end
  end

  i2c_reg_ptr #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld_q),
    .load_val_i(shift_q),
    .inc_i     (we_q | rinc_q),
    .ptr_o     (reg_addr_o)
  );

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign reg_wdata_o = wdata_q;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic [2:0]       st_i,
  input logic             sda_oe_o,
  input logic             reg_we_o,
  input logic [PTR_W-1:0] reg_addr_o
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(NUM_REGS - 1);

  p_we_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (st_i == 3'(ST_WR)));

  p_ptr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_o <= LAST_P);

  p_ptr_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == LAST_P) |=> (reg_addr_o == '0));

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o != LAST_P) |=> (reg_addr_o == $past(reg_addr_o) + PTR_W'(1)));

  p_idle_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == 3'(ST_IDLE)) |-> !sda_oe_o);

  p_oe_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .st_i      (st_q),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int Q = 8;  // clocks per quarter SCL period
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] ID_W = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] ID_R = {4'b1010, PINS, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, we, re;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [0:8];
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] exp_q [$];

  always #4 clk = ~clk;  // 125 MHz

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = mem[addr];

  i2c_reg_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dev_sel_i(PINS), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial for (int i = 0; i < 9; i++) mem[i] = 8'h30 + 8'(i);

  always @(posedge clk) if (we) mem[addr] <= wdata;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", {addr, wdata}, 0);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({addr, wdata} == e, "R5/R6 strobe addr,data", {addr, wdata}, e);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      v[i] = b;
    end
    bit_out(give_ack ? 1'b0 : 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
    chk(we == 1'b0 && re == 1'b0, "R9 strobes low", {we, re}, 0);
    rst_n = 1'b1;
    wq();

    // R3: traffic before any START is ignored
    send_byte(ID_W, a);
    chk(a == 1'b1, "R3 no ack before START", a, 1);

    // R2: wrong pins, following bytes ignored
    do_start();
    send_byte({4'b1010, 3'b001, 1'b0}, a);
    chk(a == 1'b1, "R2 pin mismatch nack", a, 1);
    send_byte(8'h03, a);
    chk(a == 1'b1, "R2 ignored after mismatch", a, 1);
    send_byte(8'h55, a);
    chk(a == 1'b1, "R2 ignored data", a, 1);
    do_stop();

    // R1 wrong prefix, correct pins
    do_start();
    send_byte({4'b0010, PINS, 1'b0}, a);
    chk(a == 1'b1, "R1 prefix mismatch nack", a, 1);
    do_stop();

    // write burst across the wrap
    do_start();
    send_byte(ID_W, a);
    chk(a == 1'b0, "R1 id ack", a, 0);
    send_byte(8'h07, a);
    chk(a == 1'b0, "R4 addr ack", a, 0);
    exp_q.push_back({4'd7, 8'h11});
    exp_q.push_back({4'd8, 8'h22});
    exp_q.push_back({4'd0, 8'h33});
    send_byte(8'h11, a); chk(a == 1'b0, "R5 data ack 0", a, 0);
    send_byte(8'h22, a); chk(a == 1'b0, "R5 data ack 1", a, 0);
    send_byte(8'h33, a); chk(a == 1'b0, "R6 data ack after wrap", a, 0);
    do_stop();
    chk(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);

    // R3: after STOP bytes are ignored
    send_byte(ID_W, a);
    chk(a == 1'b1, "R3 no ack after STOP", a, 1);

    // read burst across the wrap
    do_start();
    send_byte(ID_W, a); chk(a == 1'b0, "R7 id ack", a, 0);
    send_byte(8'h07, a); chk(a == 1'b0, "R4 addr ack rd", a, 0);
    do_start();
    send_byte(ID_R, a); chk(a == 1'b0, "R1 read id ack", a, 0);
    recv_byte(v, 1'b1); chk(v == 8'h11, "R7 read byte 7", v, 8'h11);
    recv_byte(v, 1'b1); chk(v == 8'h22, "R7 read byte 8", v, 8'h22);
    recv_byte(v, 1'b0); chk(v == 8'h33, "R6 read wrap to 0", v, 8'h33);
    // R7: after nack the bus is ignored until START
    send_byte(ID_W, a);
    chk(a == 1'b1, "R7 standby after nack", a, 1);
    do_stop();

    // pointer held at 0 across nack; read from current pointer
    do_start();
    send_byte(ID_R, a); chk(a == 1'b0, "R7 direct read ack", a, 0);
    recv_byte(v, 1'b1); chk(v == 8'h33, "R7 nack kept pointer", v, 8'h33);
    recv_byte(v, 1'b0); chk(v == 8'h31, "R6 read step", v, 8'h31);
    do_stop();

    // out-of-range address loads 0
    do_start();
    send_byte(ID_W, a);
    send_byte(8'h0C, a); chk(a == 1'b0, "R4 high addr ack", a, 0);
    exp_q.push_back({4'd0, 8'hA5});
    send_byte(8'hA5, a); chk(a == 1'b0, "R4 data ack", a, 0);
    do_stop();
    chk(exp_q.size() == 0, "R4 strobe at addr 0", exp_q.size(), 0);
    chk(sda_oe == 1'b0, "R8 released in standby", sda_oe, 0);

    wq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule